// File: doc/BRIEF.md
# Timebase Prescaler with Reference Taps

This block divides a 32.768 kHz timebase down to one pulse per second, which drives the calendar counters. The timebase arrives as a clock-enable strobe in the system clock domain, so the whole block runs on one clock. A chain of divide-by-two stages counts the strobes. The last stage of the chain is a 1 Hz square wave. On each rising edge of that square wave the block issues a one-cycle seconds tick.

Two small modulo counters follow the chain, one for seconds within a minute and one for minutes within an hour. Together with two taps of the chain they form a 4-bit reference word that a bus read can return. A post-stage clear input zeroes the top stages of the chain, so software can realign the start of a second. The lower stages keep counting, and the seconds and minutes counts are not touched.

Top module: `prescale_ref`

## Requirements
- R1: While `rstN` is low, and after it is released until the first strobe, `refWord` is 4'b0000 and `secTick` is 0.
- R2: Each cycle with `tbStrobe` high advances the divider by exactly one count. A cycle with neither `tbStrobe` nor `postClear` high changes no output, and `secTick` stays 0.
- R3: `refWord[0]` is divider stage `FAST_TAP`: it is low for 2^FAST_TAP strobes and then high for 2^FAST_TAP strobes, starting from reset. With the defaults it is the 1024 Hz tap.
- R4: `refWord[1]` is the last divider stage, the 1 Hz wave. Counting strobes n from reset, it is high when bit DIV_STAGES-1 of n is 1.
- R5: `secTick` is high for exactly the one cycle that follows the strobe on which `refWord[1]` goes from 0 to 1. At no other time is it high.
- R6: `refWord[2]` is high while the seconds count (ticks modulo SEC_PER_MIN) is at least SEC_PER_MIN/2. The count updates at the same edge as `secTick` rising.
- R7: `refWord[3]` is high while the minutes count is at least MIN_PER_HOUR/2. The minutes count is the number of seconds-count wraps, modulo MIN_PER_HOUR.
- R8: A cycle with `postClear` high sets the top POST_STAGES divider stages to 0. It leaves the lower stages and the seconds and minutes counts unchanged, and it never produces `secTick`.
- R9: When `postClear` and `tbStrobe` are high in the same cycle, the lower stages still advance by one and the top stages end at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tbStrobe | input | 1 | One-cycle enable per timebase period (32.768 kHz rate) |
| postClear | input | 1 | Clears the top POST_STAGES divider stages |
| refWord | output | 4 | {minute ref, second-count ref, 1 Hz, fast tap} |
| secTick | output | 1 | One-cycle pulse at each 1 Hz rising edge |

## Verification
The bench runs the divider with reduced parameters, so whole seconds, minutes and hours pass quickly. It follows each tap against a strobe-count model, and it inserts idle gaps between strobes. A design that advanced without a strobe, or that ticked on the falling half of the wave, would fail the tap and tick checks. A design that wrapped a counter off by one would show the second or minute reference at the wrong phase. The post-clear tests hit three cases: a clear with no strobe, a clear together with a strobe, and a clear on the very strobe that would raise the 1 Hz wave. A design that also cleared the low stages, or that let the clear raise a tick, or that lost that strobe's advance, would show a wrong reference word or a spurious tick.

// File: rtl/prescale_pkg.sv
package prescale_pkg;
  typedef struct packed {
    logic advance;
    logic clearPost;
    logic tick;
  } prescaleStrobes_t;
endpackage

// File: rtl/prescale_rollover.sv
module prescale_rollover #(
  parameter int MODULUS = 60
) (
  input  logic clk,
  input  logic rstN,
  input  logic step,
  output logic wrap,
  output logic upperHalf
);
  localparam int CW = (MODULUS > 1) ? $clog2(MODULUS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);
  localparam logic [CW-1:0] HALF = CW'(MODULUS / 2);

  logic [CW-1:0] count;

  assign wrap = step && (count == LAST);
  assign upperHalf = (count >= HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (wrap) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // shared by R6 (seconds) and R7 (minutes)
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    count <= LAST);
  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$past(step) |-> $stable(count));
endmodule

// File: rtl/prescale_ctrl.sv
module prescale_ctrl
  import prescale_pkg::*;
(
  input  logic             tbStrobe,
  input  logic             postClear,
  input  logic             preRise,
  output prescaleStrobes_t strb
);
  always_comb begin
    strb.advance   = tbStrobe;
    strb.clearPost = postClear;
    strb.tick      = tbStrobe && !postClear && preRise;
  end
endmodule

// File: rtl/prescale_datapath.sv
module prescale_datapath
  import prescale_pkg::*;
#(
  parameter int DIV_STAGES   = 15,
  parameter int POST_STAGES  = 5,
  parameter int FAST_TAP     = 4,
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60
) (
  input  logic             clk,
  input  logic             rstN,
  input  prescaleStrobes_t strb,
  output logic             preRise,
  output logic [3:0]       refWord,
  output logic             secTick
);
  localparam int TOP = DIV_STAGES - 1;
  localparam int LOW_STAGES = DIV_STAGES - POST_STAGES;

  logic [TOP:0] stages;
  logic [DIV_STAGES:0] carry;
  logic secWrap, secHalf, minWrap, minHalf;

  assign carry[0] = strb.advance;

  for (genvar i = 0; i < DIV_STAGES; i++) begin : g_stage
    assign carry[i+1] = carry[i] && stages[i];
    if (i >= LOW_STAGES) begin : g_post
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages[i] <= 1'b0;
        else if (strb.clearPost) stages[i] <= 1'b0;
        else if (carry[i]) stages[i] <= ~stages[i];
      end
    end else begin : g_pre
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stages[i] <= 1'b0;
        else if (carry[i]) stages[i] <= ~stages[i];
      end
    end
  end

  assign preRise = !stages[TOP] && (&stages[TOP-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secTick <= 1'b0;
    else secTick <= strb.tick;
  end

  prescale_rollover #(.MODULUS(SEC_PER_MIN)) i_secCount (
    .clk(clk), .rstN(rstN), .step(strb.tick), .wrap(secWrap), .upperHalf(secHalf));

  prescale_rollover #(.MODULUS(MIN_PER_HOUR)) i_minCount (
    .clk(clk), .rstN(rstN), .step(secWrap), .wrap(minWrap), .upperHalf(minHalf));

  assign refWord = {minHalf, secHalf, stages[TOP], stages[FAST_TAP]};

  assert_tick_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (stages[TOP] && !$past(stages[TOP])));
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.advance) && !$past(strb.clearPost)) |-> ($stable(stages) && !secTick));
  assert_post_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearPost) |-> (stages[TOP:LOW_STAGES] == '0));
  assert_low_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearPost && !strb.advance) |-> $stable(stages[LOW_STAGES-1:0]));
  assert_no_clear_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearPost) |-> !secTick);
  assert_wrap_order_R7: assert property (@(posedge clk) disable iff (!rstN)
    minWrap |-> secWrap);
endmodule

// File: rtl/prescale_ref.sv
module prescale_ref
  import prescale_pkg::*;
#(
  parameter int DIV_STAGES   = 15,
  parameter int POST_STAGES  = 5,
  parameter int FAST_TAP     = 4,
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tbStrobe,
  input  logic       postClear,
  output logic [3:0] refWord,
  output logic       secTick
);
  prescaleStrobes_t strb;
  logic preRise;

  prescale_ctrl i_ctrl (
    .tbStrobe(tbStrobe), .postClear(postClear), .preRise(preRise), .strb(strb));

  prescale_datapath #(
    .DIV_STAGES(DIV_STAGES), .POST_STAGES(POST_STAGES), .FAST_TAP(FAST_TAP),
    .SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_HOUR(MIN_PER_HOUR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .preRise(preRise),
    .refWord(refWord), .secTick(secTick));
endmodule

// File: tb/test_prescale_ref.sv
module test_prescale_ref;
  localparam int DIV = 6;
  localparam int POST = 3;
  localparam int FAST = 1;
  localparam int SPM = 6;
  localparam int MPH = 4;
  localparam int PERIOD = 1 << DIV;
  localparam int LOWMASK = (1 << (DIV - POST)) - 1;

  localparam int NVEC = 10;
  localparam int VEC_COUNT[NVEC] = '{1, 1, 30, 1, 31, 100, 257, 400, 700, 150};
  localparam bit VEC_GAPS[NVEC]  = '{0, 1, 0, 0, 1, 0, 1, 0, 0, 1};

  logic clk = 0;
  logic rstN = 0;
  logic tbStrobe = 0;
  logic postClear = 0;
  logic [3:0] refWord;
  logic secTick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  int mP = 0, mSec = 0, mMin = 0;
  bit mTick = 0;
  int tickBad = 0;

  always #2 clk = ~clk;

  prescale_ref #(.DIV_STAGES(DIV), .POST_STAGES(POST), .FAST_TAP(FAST),
    .SEC_PER_MIN(SPM), .MIN_PER_HOUR(MPH)) i_prescale_ref (
    .clk(clk), .rstN(rstN), .tbStrobe(tbStrobe), .postClear(postClear),
    .refWord(refWord), .secTick(secTick));

  function automatic logic [3:0] expRef();
    return {logic'(mMin >= MPH/2), logic'(mSec >= SPM/2),
            logic'((mP >> (DIV-1)) & 1), logic'((mP >> FAST) & 1)};
  endfunction

  task automatic checkRef(string req);
    checks++;
    if (refWord !== expRef()) begin
      errors++;
      $display("FAIL %s refWord actual %b expected %b", req, refWord, expRef());
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cycle(bit s, bit c);
    int oldTop;
    tbStrobe = s;
    postClear = c;
    @(posedge clk);
    #1;
    tbStrobe = 0;
    postClear = 0;
    oldTop = (mP >> (DIV-1)) & 1;
    if (s) mP = (mP + 1) % PERIOD;
    if (c) mP = mP & LOWMASK;
    mTick = s && !c && oldTop == 0 && ((mP >> (DIV-1)) & 1) == 1;
    if (mTick) begin
      mSec++;
      if (mSec == SPM) begin mSec = 0; mMin = (mMin + 1) % MPH; end
    end
    if (secTick !== mTick) tickBad++;
  endtask

  task automatic runTo(int target);
    while (mP != target) cycle(1, 0);
  endtask

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkRef("R1 in reset");
    checkBit("R1 tick in reset", secTick, 1'b0);
    rstN = 1;
    repeat (2) cycle(0, 0);
    checkRef("R1 after release");

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      tickBad = 0;
      for (int k = 0; k < VEC_COUNT[v]; k++) begin
        cycle(1, 0);
        if (VEC_GAPS[v]) cycle(0, 0);
      end
      checkRef($sformatf("R3 R4 R6 R7 vector %0d", v));
      checks++;
      if (tickBad != 0) begin
        errors++;
        $display("FAIL R5 vector %0d tick mismatches actual %0d expected 0", v, tickBad);
      end
    end

    // R2: idle cycles hold every output
    tickBad = 0;
    repeat (5) cycle(0, 0);
    checkRef("R2 idle hold");
    checkBit("R2 no tick when idle", secTick, 1'b0);

    // R5: exact tick cycle
    runTo(PERIOD/2 - 1);
    cycle(1, 0);
    checkBit("R5 tick at rise", secTick, 1'b1);
    cycle(0, 0);
    checkBit("R5 tick one cycle", secTick, 1'b0);

    // R8: clear alone with top stages set
    runTo(PERIOD/2 + 5);
    cycle(0, 1);
    checkRef("R8 clear keeps low stages and counts");
    checkBit("R8 no tick on clear", secTick, 1'b0);

    // R9: clear with strobe
    runTo(PERIOD - 3);
    cycle(1, 1);
    checkRef("R9 clear with strobe advances low stages");

    // R8: clear on the strobe that would raise the 1 Hz wave
    runTo(PERIOD/2 - 1);
    tickBad = 0;
    cycle(1, 1);
    checkBit("R8 clear suppresses tick", secTick, 1'b0);
    checkRef("R8 clear at rise");
    runTo(PERIOD/2 - 1);
    cycle(1, 0);
    checkBit("R5 tick after realign", secTick, 1'b1);
    checkRef("R4 after realign");

    // R1: reset mid-run
    #1 rstN = 0;
    #1;
    mP = 0; mSec = 0; mMin = 0;
    checkRef("R1 async reset mid-run");
    rstN = 1;
    cycle(0, 0);
    checkRef("R1 after second release");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule